// File: doc/BRIEF.md
# Nibble-Command Register Access Port

This block sits on the device side of a byte-wide command stream and turns it into accesses to a small register file. Every command byte is split in two. Bits [7:4] hold an opcode and bits [3:0] hold a four-bit payload. An 8-bit register address is built from two payload nibbles. A data byte is built from a staged low nibble and the payload of the command that performs the write.

The register file has three registers:
- an identity register that always reads 0xA6;
- a scratch register that can be read and written;
- a mode register whose value drives an output. The value 0x80 selects logic-analyzer mode.

Each read command puts exactly one byte on a response stream. The response stream uses a valid/ready handshake and has a small output FIFO. When the FIFO is full, the command stream is back-pressured.

Top module: `nib_cmd_port`

## Requirements
- R1: After reset, `rsp_valid` is 0, `cmd_ready` is 1, `mode_o` is 0x00, `la_mode_o` is 0, and the address and staged nibble are 0.
- R2: Opcode 0x0 loads address bits [3:0] from the payload. Opcode 0x1 loads address bits [7:4] from the payload. The address keeps its value across all other commands, so later accesses reuse it.
- R3: Opcode 0x2 only stages the payload as the low data nibble. It changes no register.
- R4: Opcode 0x3 writes the byte {payload, staged nibble} to the register at the current address.
- R5: The identity register at address 0x00 always reads 0xA6. Writes to it have no effect.
- R6: The scratch register at address 0x01 reads back the last byte written to it.
- R7: Opcode 0x4 pushes exactly one response byte: the value of the addressed register. Responses leave in the same order as the read commands. The burst "ID read, write 0x55, read, write 0xAA, read" returns A6, 55, AA.
- R8: The mode register at address 0x02 is readable and writable and drives `mode_o`. `la_mode_o` is 1 exactly when the mode value is 0x80.
- R9: Reads of any address other than 0x00, 0x01 and 0x02 return 0x00. Writes to those addresses have no effect.
- R10: Opcodes 0x5 to 0xF change no state and produce no response.
- R11: While the response FIFo holds DEPTH bytes, `cmd_ready` is 0. While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_byte` holds steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command byte is offered |
| cmd_ready | output | 1 | The port can accept a command |
| cmd_byte | input | 8 | Command: opcode in [7:4], payload in [3:0] |
| rsp_valid | output | 1 | A response byte is available |
| rsp_ready | input | 1 | The consumer takes the response byte |
| rsp_byte | output | 8 | Response byte at the head of the FIFO |
| mode_o | output | 8 | Current mode register value |
| la_mode_o | output | 1 | Logic-analyzer mode selected |

## Verification
The hardest condition to reach is a full response FIFO. It needs several read commands queued while the consumer refuses data, and reads of different registers so that the drain order is visible. The bench holds `rsp_ready` low and issues DEPTH reads at distinct addresses. It then checks that `cmd_ready` has dropped and that the head byte stays stable for several cycles. Finally it drains the FIFO and compares each byte against the order of the reads.

// File: rtl/nib_cmd_port.sv
module nib_cmd_port #(
  parameter int         DEPTH       = 4,
  parameter logic [7:0] ID_VALUE    = 8'hA6,
  parameter logic [7:0] ID_ADDR     = 8'h00,
  parameter logic [7:0] SCRATCH_ADDR = 8'h01,
  parameter logic [7:0] MODE_ADDR   = 8'h02,
  parameter logic [7:0] LA_MODE_VAL = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [7:0] cmd_byte,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_byte,
  output logic [7:0] mode_o,
  output logic       la_mode_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = IW + 1;
  localparam logic [3:0] OP_ADDR_LO = 4'h0;
  localparam logic [3:0] OP_ADDR_HI = 4'h1;
  localparam logic [3:0] OP_DATA_LO = 4'h2;
  localparam logic [3:0] OP_WRITE   = 4'h3;
  localparam logic [3:0] OP_READ    = 4'h4;

  logic [3:0] op, pl;
  logic       acc, push, pop, full;
  logic [7:0] addr_q, scratch_q, mode_q, rd_val, wr_val;
  logic [3:0] lo_q;
  logic [PW-1:0] wr_ptr, rd_ptr, count;
  logic [7:0] mem [DEPTH];

  assign op        = cmd_byte[7:4];
  assign pl        = cmd_byte[3:0];
  assign count     = wr_ptr - rd_ptr;
  assign full      = (count == PW'(DEPTH));
  assign cmd_ready = !full;
  assign acc       = cmd_valid && cmd_ready;
  assign push      = acc && (op == OP_READ);
  assign rsp_valid = (count != '0);
  assign pop       = rsp_valid && rsp_ready;
  assign rsp_byte  = mem[rd_ptr[IW-1:0]];
  assign wr_val    = {pl, lo_q};
  assign mode_o    = mode_q;
  assign la_mode_o = (mode_q == LA_MODE_VAL);

  always_comb begin
    if (addr_q == ID_ADDR)           rd_val = ID_VALUE;
    else if (addr_q == SCRATCH_ADDR) rd_val = scratch_q;
    else if (addr_q == MODE_ADDR)    rd_val = mode_q;
    else                             rd_val = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      lo_q      <= '0;
      scratch_q <= '0;
      mode_q    <= '0;
    end else if (acc) begin
      case (op)
        OP_ADDR_LO: addr_q[3:0] <= pl;
        OP_ADDR_HI: addr_q[7:4] <= pl;
        OP_DATA_LO: lo_q <= pl;
        OP_WRITE: begin
          if (addr_q == SCRATCH_ADDR) scratch_q <= wr_val;
          if (addr_q == MODE_ADDR)    mode_q    <= wr_val;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr[IW-1:0]] <= rd_val;
        wr_ptr <= wr_ptr + PW'(1);
      end
      if (pop) rd_ptr <= rd_ptr + PW'(1);
    end
  end

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= PW'(DEPTH));

  a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_byte)));

  a_r7_one_per_read: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (count == $past(count) + PW'(1)));

  a_r5_id_value: assert property (@(posedge clk) disable iff (!rst_n)
    (push && addr_q == ID_ADDR && !rsp_valid) |=> (rsp_valid && rsp_byte == ID_VALUE));

  a_r10_ignored_op: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op > OP_READ) |=> ($stable(addr_q) && $stable(lo_q) &&
                               $stable(scratch_q) && $stable(mode_q)));

  a_r1_reset_state: assert property (@(posedge clk)
    $past(!rst_n) |-> (!rsp_valid && cmd_ready && mode_o == 8'h00));
endmodule

// File: tb/nib_cmd_port_tb_top.sv
module nib_cmd_port_tb_top;
  localparam int DEPTH = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, rsp_ready = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic cmd_ready, rsp_valid, la_mode_o;
  logic [7:0] rsp_byte, mode_o;
  int checks = 0, failures = 0, cycles = 0;

  always #2 clk = ~clk;

  nib_cmd_port #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_byte(cmd_byte), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_byte(rsp_byte), .mode_o(mode_o), .la_mode_o(la_mode_o));

  localparam int NSEQ = 13;
  localparam logic [7:0] SEQ [NSEQ] = '{
    8'h00, 8'h10, 8'h40,
    8'h01, 8'h25, 8'h35, 8'h40,
    8'h2A, 8'h3A, 8'h40,
    8'h02, 8'h20, 8'h38};
  localparam logic [7:0] EXP [3] = '{8'hA6, 8'h55, 8'hAA};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = b;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic pop_check(input string req, input logic [7:0] exp);
    @(negedge clk);
    check({req, " valid"}, 32'(rsp_valid), 32'd1);
    check(req, 32'(rsp_byte), 32'(exp));
    rsp_ready = 1'b1;
    @(posedge clk);
    #1 rsp_ready = 1'b0;
  endtask

  task automatic set_addr(input logic [7:0] a);
    send({4'h0, a[3:0]});
    send({4'h1, a[7:4]});
  endtask

  task automatic write_byte(input logic [7:0] d);
    send({4'h2, d[3:0]});
    send({4'h3, d[7:4]});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R1 cmd_ready", 32'(cmd_ready), 32'd1);
    check("R1 mode_o", 32'(mode_o), 32'h00);
    check("R1 la_mode_o", 32'(la_mode_o), 32'd0);

    for (int i = 0; i < NSEQ; i++) send(SEQ[i]);
    for (int i = 0; i < 3; i++) pop_check("R7 burst", EXP[i]);
    @(negedge clk);
    check("R7 no extra response", 32'(rsp_valid), 32'd0);
    check("R8 mode_o", 32'(mode_o), 32'h80);
    check("R8 la_mode_o", 32'(la_mode_o), 32'd1);

    send(8'h40);
    pop_check("R2 address reused", 8'h80);

    set_addr(8'h01);
    send(8'h23);
    send(8'h40);
    pop_check("R3 low nibble only staged", 8'hAA);
    send(8'h3C);
    send(8'h40);
    pop_check("R4 write uses staged nibble", 8'hC3);
    write_byte(8'h00);
    send(8'h40);
    pop_check("R6 scratch readback", 8'h00);
    write_byte(8'h5A);

    set_addr(8'h00);
    write_byte(8'h12);
    send(8'h40);
    pop_check("R5 id unchanged", 8'hA6);

    set_addr(8'h5B);
    send(8'h40);
    pop_check("R9 unmapped read", 8'h00);
    write_byte(8'hEE);
    send(8'h40);
    pop_check("R9 unmapped write ignored", 8'h00);

    set_addr(8'h01);
    send(8'h7F);
    send(8'hF3);
    send(8'h9A);
    send(8'h50);
    @(negedge clk);
    check("R10 no response", 32'(rsp_valid), 32'd0);
    send(8'h40);
    pop_check("R10 state unchanged", 8'h5A);

    set_addr(8'h02);
    write_byte(8'h81);
    @(negedge clk);
    check("R8 la_mode off", 32'(la_mode_o), 32'd0);
    check("R8 mode value", 32'(mode_o), 32'h81);

    set_addr(8'h00); send(8'h40);
    set_addr(8'h01); send(8'h40);
    set_addr(8'h02); send(8'h40);
    set_addr(8'h33); send(8'h40);
    @(negedge clk);
    check("R11 cmd_ready low when full", 32'(cmd_ready), 32'd0);
    repeat (3) begin
      @(negedge clk);
      check("R11 head stable", 32'(rsp_byte), 32'hA6);
    end
    pop_check("R11 drain 0", 8'hA6);
    @(negedge clk);
    check("R11 cmd_ready back", 32'(cmd_ready), 32'd1);
    pop_check("R11 drain 1", 8'h5A);
    pop_check("R11 drain 2", 8'h81);
    pop_check("R11 drain 3", 8'h00);
    @(negedge clk);
    check("R11 empty", 32'(rsp_valid), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule